// File: doc/BRIEF.md
# Random Bit Harvester with Masked Control Register

This block collects random bits into a bank of eight 32-bit result words on request. Software sets up a request through a small 32-bit register bus with address, write data, write strobe and read data. It chooses one of four entropy streams, a request size of 64, 128, 192 or 256 bits, and the number of clock cycles between two samples. It then sets a self-clearing go flag and polls that flag until hardware drops it. At that point the requested bits are in the result words.

The physical oscillators are not part of the block. They are modelled by four free-running linear feedback shift registers. Source 0 advances every cycle and source k advances once every 2^k cycles, so the streams run from fastest to slowest. A sample timer takes one bit from the chosen stream each period and hands it to the collector together with a valid strobe.

The control register is updated under a per-bit mask. The upper half of each write says which of the lower sixteen bits may change. A single write can therefore set or clear one field without a read-modify-write.

Top module: `trng_ctrl`

## Requirements
- R1: A write to the control register (offset 0x400) changes bit n of the register only when write-data bit n+16 is 1. Every other bit keeps its value.
- R2: Control register layout: bit 0 GO, bit 1 RUN_EN, bits [3:2] stream select, bits [5:4] size code. Bits [31:6] read as zero. After reset the control register reads 0, the period register (0x404) reads 100 and all result words read 0.
- R3: Result word i is read at offset 0x410+4*i, for i from 0 to 7. Reads of any other offset, including misaligned ones, return 0. Writes to other offsets, including the result words, change nothing.
- R4: Setting GO while RUN_EN is (or becomes) 0 has no effect: GO reads back 0 and the result words are not touched.
- R5: Size code c requests (c+1)*64 bits. With period P, GO reads 1 through clock edge N*P-1 after the launching write edge and reads 0 from edge N*P on, where N is the requested bit count. RUN_EN stays 1.
- R6: A period value of 0 behaves exactly like a period of 1.
- R7: A launch clears all eight result words in the same edge. After completion, the words beyond the requested size read 0.
- R8: Bits are placed starting at bit 0 of word 0, upward, one per sample. After k samples, no bit at or above index k is set.
- R9: Reading result words during a request returns the partial contents and does not change the completion edge.
- R10: Writing 0xFFFF0000 to the control register clears GO and RUN_EN at once. No further bits are collected, and the result words hold their values.
- R11: The stream select chooses one of four independent bit streams. Requests on different streams produce different data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
A wrong sample-timer or bit-counter state shows up as GO falling on the wrong edge. The bench therefore checks GO on the exact edges N*P-1 and N*P after launch, so an off-by-one in either counter is caught on the first request. A bad fill pointer or a missed clear leaves bits set above the pointer or in words past the requested size. The bench sees this in the first result read, partway through a request or right after launch. A broken write mask corrupts a neighbouring field, and the next control read exposes it.

// File: rtl/trng_pkg.sv
package trng_pkg;

    // Control register fields, packed so that bit 0 is GO
    typedef struct packed {
        logic [1:0] size;
        logic [1:0] src;
        logic       run_en;
        logic       go;
    } ctrl_t;

    localparam int CTRL_W   = $bits(ctrl_t);
    localparam int OFS_CTRL = 'h400;
    localparam int OFS_PER  = 'h404;
    localparam int OFS_DATA = 'h410;
    localparam int MASK_LSB = 16;

endpackage

// File: rtl/trng_bitsrc.sv
module trng_bitsrc #(
    parameter int          NSRC   = 4,
    parameter int          LFSR_W = 32,
    parameter int          CNT_W  = 16,
    parameter logic [31:0] POLY   = 32'h8020_0003,
    parameter logic [31:0] SEED   = 32'hACE1_5A5A
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     restart,
    input  logic [$clog2(NSRC)-1:0]  sel,
    input  logic [CNT_W-1:0]         period,
    output logic                     bit_o,
    output logic                     strobe_o
);
    localparam int PRE_W = NSRC;

    typedef struct packed {
        logic [NSRC-1:0][LFSR_W-1:0] lfsr;
        logic [PRE_W-1:0]            pre;
        logic [CNT_W-1:0]            cnt;
    } st_t;

    function automatic st_t reset_state();
        st_t s;
        s = '0;
        for (int i = 0; i < NSRC; i++) begin
            s.lfsr[i] = LFSR_W'(SEED) ^ (LFSR_W'(i + 1) * LFSR_W'(32'h9E37_79B9));
        end
        return s;
    endfunction

    localparam st_t ST_RST = reset_state();

    st_t st_d, st_q;
    logic [CNT_W-1:0] per_eff;

    always_comb begin
        st_d     = st_q;
        st_d.pre = st_q.pre + 1'b1;
        per_eff  = (period == '0) ? CNT_W'(1) : period;
        for (int i = 0; i < NSRC; i++) begin
            if ((st_q.pre & PRE_W'((1 << i) - 1)) == '0) begin
                st_d.lfsr[i] = st_q.lfsr[i][0]
                             ? ((st_q.lfsr[i] >> 1) ^ LFSR_W'(POLY))
                             : (st_q.lfsr[i] >> 1);
            end
        end
        strobe_o = 1'b0;
        if (restart || !run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= per_eff - 1'b1) begin
            st_d.cnt = '0;
            strobe_o = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        bit_o = st_q.lfsr[sel][0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    // R5
    sample_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && period > CNT_W'(1)) |=> (!strobe_o || period != $past(period)));

endmodule

// File: rtl/trng_collect.sv
module trng_collect #(
    parameter int WORDS = 8,
    parameter int LEN_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic [LEN_W-1:0]      size,
    input  logic                  strobe,
    input  logic                  bit_i,
    output logic [WORDS*32-1:0]   data_o,
    output logic                  last_o
);
    localparam int TOTAL = WORDS * 32;
    localparam int CHUNK = TOTAL / (1 << LEN_W);
    localparam int IDX_W = $clog2(TOTAL + 1);
    localparam int BIT_W = $clog2(TOTAL);

    typedef struct packed {
        logic [TOTAL-1:0] data;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] target;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        last_o = 1'b0;
        if (clear) begin
            st_d.data   = '0;
            st_d.idx    = '0;
            st_d.target = (IDX_W'(size) + 1'b1) * IDX_W'(CHUNK);
        end else if (strobe && st_q.idx < st_q.target) begin
            st_d.data[st_q.idx[BIT_W-1:0]] = bit_i;
            st_d.idx = st_q.idx + 1'b1;
            last_o   = (st_q.idx == st_q.target - 1'b1);
        end
        data_o = st_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= st_q.target);

    // R8
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.data >> st_q.idx) == '0);

endmodule

// File: rtl/trng_ctrl.sv
module trng_ctrl
    import trng_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int WORDS    = 8,
    parameter int NSRC     = 4,
    parameter int CNT_W    = 16,
    parameter int PER_RST  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata
);
    localparam int SEL_W = $clog2(NSRC);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] per;
    } regs_t;

    regs_t r_d, r_q;
    ctrl_t wr;
    logic  launch;
    logic  bit_s, strobe_s, last_s;
    logic [WORDS*32-1:0] words;

    logic wr_ctrl, wr_per;
    assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_per  = bus_we && (bus_addr == ADDR_W'(OFS_PER));

    always_comb begin
        r_d = r_q;
        wr  = r_q.ctrl;
        if (wr_ctrl) begin
            wr = (r_q.ctrl & ~ctrl_t'(bus_wdata[MASK_LSB +: CTRL_W]))
               | (ctrl_t'(bus_wdata[CTRL_W-1:0]) & ctrl_t'(bus_wdata[MASK_LSB +: CTRL_W]));
        end
        if (!wr.run_en) wr.go = 1'b0;
        launch = wr.go && !r_q.ctrl.go;
        r_d.ctrl = wr;
        if (last_s) r_d.ctrl.go = 1'b0;
        if (wr_per) r_d.per = bus_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl <= '0;
            r_q.per  <= CNT_W'(PER_RST);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL)) bus_rdata = 32'(r_q.ctrl);
        if (bus_addr == ADDR_W'(OFS_PER))  bus_rdata = 32'(r_q.per);
        for (int i = 0; i < WORDS; i++) begin
            if (bus_addr == ADDR_W'(OFS_DATA + 4 * i)) bus_rdata = words[i*32 +: 32];
        end
    end

    trng_bitsrc #(
        .NSRC  (NSRC),
        .CNT_W (CNT_W)
    ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (r_q.ctrl.go),
        .restart  (launch),
        .sel      (r_q.ctrl.src[SEL_W-1:0]),
        .period   (r_q.per),
        .bit_o    (bit_s),
        .strobe_o (strobe_s)
    );

    trng_collect #(
        .WORDS (WORDS),
        .LEN_W (2)
    ) u_col (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (launch),
        .size   (wr.size),
        .strobe (strobe_s),
        .bit_i  (bit_s),
        .data_o (words),
        .last_o (last_s)
    );

    // R4
    go_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ctrl.go |-> r_q.ctrl.run_en);

    // R1
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[21:18] == 4'h0) |=> ($stable(r_q.ctrl.size) && $stable(r_q.ctrl.src)));

    // R10
    stop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata == 32'hFFFF_0000) |=> (!r_q.ctrl.go && !r_q.ctrl.run_en));

    // R5
    go_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_s && !wr_ctrl) |=> (!r_q.ctrl.go && r_q.ctrl.run_en));

endmodule

// File: tb/trng_ctrl_tb.sv
`timescale 1ns/1ps
module trng_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    int errors = 0;
    int checks = 0;

    localparam logic [11:0] A_CTRL = 12'h400;
    localparam logic [11:0] A_PER  = 12'h404;
    localparam logic [11:0] A_DATA = 12'h410;

    always #2 clk = ~clk;

    trng_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = '0;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic launch(input int size, input int src);
        wr(A_CTRL, 32'h003F_0000 | 32'(size << 4) | 32'(src << 2) | 32'h3);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL, v); check(v == 32'h0, "R2 reset ctrl", v, 32'h0);
        rd(A_PER, v);  check(v == 32'd100, "R2 reset period", v, 32'd100);
        for (int i = 0; i < 8; i++) begin
            rd(A_DATA + 12'(4 * i), v); check(v == 32'h0, "R2 reset word", v, 32'h0);
        end
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(A_CTRL, 32'h0002_0002);
        rd(A_CTRL, v); check(v == 32'h02, "R1 set enable", v, 32'h02);
        wr(A_CTRL, 32'h000C_003C);
        rd(A_CTRL, v); check(v == 32'h0E, "R1 src only", v, 32'h0E);
        wr(A_CTRL, 32'h0000_FFFF);
        rd(A_CTRL, v); check(v == 32'h0E, "R1 no mask", v, 32'h0E);
        wr(A_CTRL, 32'h0030_0010);
        rd(A_CTRL, v); check(v == 32'h1E, "R1 size only", v, 32'h1E);
        wr(A_CTRL, 32'hFFFF_FFFE);
        rd(A_CTRL, v); check(v == 32'h3E, "R2 upper bits zero", v, 32'h3E);
        wr(A_CTRL, 32'hFFFF_0000);
        rd(A_CTRL, v); check(v == 32'h0, "R1 full clear", v, 32'h0);
    endtask

    task automatic t_no_enable();
        logic [31:0] v;
        wr(A_CTRL, 32'h0001_0001);
        rd(A_CTRL, v); check(v == 32'h0, "R4 go without enable", v, 32'h0);
        edges(150);
        rd(A_DATA, v); check(v == 32'h0, "R4 words untouched", v, 32'h0);
    endtask

    task automatic t_sizes();
        logic [31:0] v;
        wr(A_PER, 32'd2);
        for (int s = 0; s < 4; s++) begin
            int n;
            bit any;
            n = (s + 1) * 64;
            launch(s, 0);
            edges(n * 2 - 1);
            rd(A_CTRL, v); check(v[0] == 1'b1, "R5 go still set", v, 32'(v | 1));
            edges(1);
            rd(A_CTRL, v);
            check(v == 32'(3'b010 | (s << 4)), "R5 go cleared on time", v, 32'(3'b010 | (s << 4)));
            any = 1'b0;
            for (int i = 0; i < 8; i++) begin
                rd(A_DATA + 12'(4 * i), v);
                if (i >= 2 * (s + 1)) check(v == 32'h0, "R7 word beyond size", v, 32'h0);
                else if (v != 0) any = 1'b1;
            end
            check(any, "R5 data collected", 32'(any), 32'h1);
        end
    endtask

    task automatic t_zero_period();
        logic [31:0] v;
        wr(A_PER, 32'd0);
        rd(A_PER, v); check(v == 32'h0, "R6 period reads 0", v, 32'h0);
        launch(0, 0);
        edges(63);
        rd(A_CTRL, v); check(v[0] == 1'b1, "R6 go before 64", v, 32'h3);
        edges(1);
        rd(A_CTRL, v); check(v[0] == 1'b0, "R6 done at 64", v, 32'h2);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(A_PER, 32'd1);
        launch(3, 1);
        edges(260);
        wr(A_PER, 32'd50);
        launch(0, 0);
        for (int i = 0; i < 8; i++) begin
            rd(A_DATA + 12'(4 * i), v); check(v == 32'h0, "R7 cleared on launch", v, 32'h0);
        end
        wr(A_CTRL, 32'hFFFF_0000);
    endtask

    task automatic t_partial();
        logic [31:0] v;
        wr(A_PER, 32'd10);
        launch(0, 2);
        edges(55);
        rd(A_DATA, v); check((v >> 5) == 32'h0, "R8 only 5 low bits", v, v & 32'h1F);
        rd(A_DATA + 12'd4, v); check(v == 32'h0, "R8 word1 empty", v, 32'h0);
        rd(A_CTRL, v); check(v[0] == 1'b1, "R9 running after reads", v, 32'h0B);
        edges(640 - 55 - 1);
        rd(A_CTRL, v); check(v[0] == 1'b1, "R9 go before end", v, 32'h0B);
        edges(1);
        rd(A_CTRL, v); check(v[0] == 1'b0, "R9 end unchanged", v, 32'h0A);
    endtask

    task automatic t_stop();
        logic [31:0] v, a;
        wr(A_PER, 32'd3);
        launch(3, 0);
        edges(100);
        wr(A_CTRL, 32'hFFFF_0000);
        rd(A_CTRL, v); check(v == 32'h0, "R10 stopped", v, 32'h0);
        rd(A_DATA + 12'd4, a);
        edges(120);
        rd(A_DATA + 12'd4, v); check(v == a, "R10 words frozen", v, a);
        rd(A_DATA + 12'd8, v); check(v == 32'h0, "R10 no more bits", v, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v, a, c;
        wr(12'h408, 32'hFFFF_FFFF);
        rd(12'h408, v); check(v == 32'h0, "R3 unmapped read", v, 32'h0);
        rd(12'h430, v); check(v == 32'h0, "R3 past last word", v, 32'h0);
        rd(12'h411, v); check(v == 32'h0, "R3 misaligned", v, 32'h0);
        rd(A_DATA, a);
        wr(A_DATA, 32'h1234_5678);
        rd(A_DATA, v); check(v == a, "R3 word read only", v, a);
        rd(A_CTRL, c);
        wr(12'h000, 32'h003F_003F);
        rd(A_CTRL, v); check(v == c, "R3 stray write ctrl", v, c);
        rd(A_PER, v); check(v == 32'd3, "R3 stray write period", v, 32'd3);
    endtask

    task automatic t_src();
        logic [31:0] a0, a1, b0, b1;
        wr(A_PER, 32'd1);
        launch(0, 0);
        edges(70);
        rd(A_DATA, a0); rd(A_DATA + 12'd4, a1);
        launch(0, 3);
        edges(70);
        rd(A_DATA, b0); rd(A_DATA + 12'd4, b1);
        check({a0, a1} != {b0, b1}, "R11 streams differ", b0, a0);
    endtask

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(2);
        t_reset();
        t_mask();
        t_no_enable();
        t_sizes();
        t_zero_period();
        t_clear();
        t_partial();
        t_stop();
        t_unmapped();
        t_src();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule